// File: doc/BRIEF.md
# Linked-List Memory-to-Stream DMA Engine

The engine follows a chain of buffer descriptors kept in memory and sends the buffers they point to out on a word-wide data stream. Each descriptor takes nine 32-bit words, in this order: next-descriptor pointer at byte offset 0, buffer address at 4, control at 8, status at 12, and five application words at 16 through 32. All memory traffic goes through a single request/response port that has at most one access in flight: descriptor fetches, buffer reads and status write-back.

Software loads the current-descriptor pointer and then sets the run bit. Fetching begins when the tail pointer is written. A descriptor with the start-of-frame flag first sends its five application words on a separate side-band stream. Every descriptor adds its buffer words to the open packet, and the packet closes on the end-of-frame descriptor. Once a descriptor has been sent, its status word is written back and the walk moves to the next pointer. The walk stops at the tail, where the engine goes idle. It also stops at a descriptor that is already marked done, where the engine halts. Each finished descriptor produces a one-cycle pulse for the interrupt logic.

Top module: `sgdma_mm2s`

## Requirements
- R1: After reset the engine reports halted=1, idle=0 and cur_ptr=0, with no memory request and no stream word valid.
- R2: A control write with the reset flag set raises st_rst_busy for exactly the following cycle, clears run, and returns the status to halted=1, idle=0.
- R3: A control write with run=1 clears both halted and idle, unless st_rst_busy is high, in which case the write changes no status.
- R4: No descriptor is fetched while run is clear, while halted is set or while idle is set. A tail-pointer write clears idle and, with run set and halted clear, starts fetching at cur_ptr.
- R5: Descriptor words are read from cur_ptr+0, +4, +8 and +12. In the control word, bits [22:0] give the byte length, bit 27 marks start-of-frame and bit 26 marks end-of-frame. The buffer goes out as ceil(length/4) words, read upward from the buffer address.
- R6: A fetched descriptor whose status bit 31 is already set makes the engine set halted and stop. Nothing is sent and nothing is written to memory.
- R7: On a start-of-frame descriptor, the five application words (cur_ptr+16 upward) go out on the control stream before any data word, with ctl_last on the fifth word only.
- R8: A packet can span several descriptors. tx_last is asserted only on the final word of an end-of-frame descriptor.
- R9: After a descriptor's data has been sent, the value length | 0x8000_0000 is written to its status word at cur_ptr+12.
- R10: After write-back, desc_done pulses for one cycle and cur_ptr takes the next pointer. If the finished descriptor was at the tail pointer, idle is set and fetching stops. Otherwise the next descriptor is fetched.
- R11: A stream word is consumed only in a cycle where valid and ready are both high, and it stays stable until then. A memory request holds its address, direction and data until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_run | input | 1 | Run flag of the control write |
| ctrl_reset | input | 1 | Reset flag of the control write |
| cur_wr | input | 1 | Load current-descriptor pointer (taken while the walker is idle) |
| tail_wr | input | 1 | Load tail pointer and start fetching |
| ptr_wdata | input | AW | Pointer value for cur_wr / tail_wr |
| cur_ptr | output | AW | Current-descriptor pointer |
| st_halted | output | 1 | Halted status |
| st_idle | output | 1 | Idle status |
| st_rst_busy | output | 1 | Reset flag, self-clearing |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted / read data valid |
| mem_rdata | input | 32 | Read data |
| tx_data | output | 32 | Data stream word |
| tx_valid | output | 1 | Data stream valid |
| tx_ready | input | 1 | Data stream ready |
| tx_last | output | 1 | Last word of packet |
| ctl_data | output | 32 | Side-band control word |
| ctl_valid | output | 1 | Control stream valid |
| ctl_ready | input | 1 | Control stream ready |
| ctl_last | output | 1 | Fifth application word |
| desc_done | output | 1 | One pulse per completed descriptor |

## Verification
The hardest case to reach is a packet that spans three descriptors while both streams apply backpressure and every memory response arrives late. In that case tx_last has to stay low across the descriptor boundaries, and the status write-back has to sit between the stalled data beats. The bench builds this chain in its memory model, drops tx_ready and ctl_ready in a repeating pattern, and stretches memory latency, then compares the captured words, the last flags and the written-back statuses against values worked out from the descriptor layout. Halting on an already-done descriptor is reached by pointing the engine at such a descriptor before setting run.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int WORD_W    = 32;
  localparam int LEN_W     = 23;
  localparam int CNT_W     = LEN_W - 1;
  localparam int SOF_BIT   = 27;
  localparam int EOF_BIT   = 26;
  localparam int DONE_BIT  = 31;
  localparam int APP_WORDS = 5;
  localparam int HDR_WORDS = 4;

  typedef enum logic [2:0] {
    W_IDLE, W_DESC, W_APP_RD, W_APP_TX, W_DAT_RD, W_DAT_TX, W_WB, W_NEXT
  } walk_st_e;

  // byte length -> number of stream words (rounded up)
  function automatic logic [CNT_W-1:0] words_of(input logic [LEN_W-1:0] len);
    logic [LEN_W:0] sum;
    sum = {1'b0, len} + (LEN_W+1)'(3);
    return sum[LEN_W:2];
  endfunction

  // value written back into a finished descriptor's status word
  function automatic logic [WORD_W-1:0] status_word(input logic [LEN_W-1:0] len);
    logic [WORD_W-1:0] w;
    w = '0;
    w[LEN_W-1:0] = len;
    w[DONE_BIT]  = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/sgdma_csr.sv
module sgdma_csr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          ctrl_run,
  input  logic          ctrl_reset,
  input  logic          tail_wr,
  input  logic [AW-1:0] ptr_wdata,
  input  logic          evt_halt,
  input  logic          evt_idle,
  output logic [AW-1:0] tail_ptr,
  output logic          halted,
  output logic          idle,
  output logic          rst_busy,
  output logic          go
);
  logic run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      halted   <= 1'b1;
      idle     <= 1'b0;
      rst_busy <= 1'b0;
      tail_ptr <= '0;
    end else begin
      rst_busy <= ctrl_wr && ctrl_reset;
      if (tail_wr) tail_ptr <= ptr_wdata;
      if (ctrl_wr && ctrl_reset) begin
        run_q  <= 1'b0;
        halted <= 1'b1;
        idle   <= 1'b0;
      end else begin
        if (evt_halt) halted <= 1'b1;
        if (evt_idle) idle <= 1'b1;
        if (tail_wr)  idle <= 1'b0;
        if (ctrl_wr) begin
          run_q <= ctrl_run;
          if (ctrl_run && !rst_busy) begin
            halted <= 1'b0;
            idle   <= 1'b0;
          end
        end
      end
    end
  end

  assign go = run_q && !halted && !idle && !rst_busy;
endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
  import sgdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              flush,
  input  logic              cur_wr,
  input  logic [AW-1:0]     ptr_wdata,
  input  logic [AW-1:0]     tail_ptr,
  output logic [AW-1:0]     cur_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_last,
  output logic [WORD_W-1:0] ctl_data,
  output logic              ctl_valid,
  input  logic              ctl_ready,
  output logic              ctl_last,
  output logic              evt_halt,
  output logic              evt_idle,
  output logic              desc_done
);
  localparam logic [2:0] IDX_STAT = 3'(HDR_WORDS - 1);
  localparam logic [2:0] IDX_APPL = 3'(APP_WORDS - 1);
  localparam logic [AW-1:0] APP_OFS  = AW'(HDR_WORDS * 4);
  localparam logic [AW-1:0] STAT_OFS = AW'((HDR_WORDS - 1) * 4);

  walk_st_e          st;
  logic [2:0]        idx;
  logic [AW-1:0]     nxt, bufa, rd_ptr;
  logic [WORD_W-1:0] ctrl_w, hold;
  logic [CNT_W-1:0]  rem, nwords;
  logic [LEN_W-1:0]  len;
  logic              sof, eof;
  walk_st_e          data_st;

  assign len     = ctrl_w[LEN_W-1:0];
  assign sof     = ctrl_w[SOF_BIT];
  assign eof     = ctrl_w[EOF_BIT];
  assign nwords  = words_of(len);
  assign data_st = (nwords == '0) ? W_WB : W_DAT_RD;

  always_comb begin
    mem_addr = cur_ptr;
    unique case (st)
      W_DESC:   mem_addr = cur_ptr + (AW'(idx) << 2);
      W_APP_RD: mem_addr = cur_ptr + APP_OFS + (AW'(idx) << 2);
      W_DAT_RD: mem_addr = rd_ptr;
      W_WB:     mem_addr = cur_ptr + STAT_OFS;
      default:  mem_addr = cur_ptr;
    endcase
  end

  assign mem_req   = (st == W_DESC) || (st == W_APP_RD) || (st == W_DAT_RD) || (st == W_WB);
  assign mem_we    = (st == W_WB);
  assign mem_wdata = status_word(len);
  assign tx_valid  = (st == W_DAT_TX);
  assign tx_data   = hold;
  assign tx_last   = tx_valid && eof && (rem == CNT_W'(1));
  assign ctl_valid = (st == W_APP_TX);
  assign ctl_data  = hold;
  assign ctl_last  = ctl_valid && (idx == IDX_APPL);
  assign evt_halt  = (st == W_DESC) && mem_ack && (idx == IDX_STAT) && mem_rdata[DONE_BIT];
  assign evt_idle  = (st == W_NEXT) && (cur_ptr == tail_ptr);
  assign desc_done = (st == W_NEXT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= W_IDLE;
      idx     <= '0;
      cur_ptr <= '0;
      nxt     <= '0;
      bufa    <= '0;
      rd_ptr  <= '0;
      ctrl_w  <= '0;
      hold    <= '0;
      rem     <= '0;
    end else if (flush) begin
      st <= W_IDLE;
    end else begin
      unique case (st)
        W_IDLE: begin
          if (cur_wr) cur_ptr <= ptr_wdata;
          else if (go) begin
            st  <= W_DESC;
            idx <= '0;
          end
        end
        W_DESC: if (mem_ack) begin
          idx <= idx + 3'd1;
          unique case (idx)
            3'd0:    nxt    <= mem_rdata[AW-1:0];
            3'd1:    bufa   <= mem_rdata[AW-1:0];
            3'd2:    ctrl_w <= mem_rdata;
            default: begin
              if (mem_rdata[DONE_BIT]) st <= W_IDLE;
              else if (sof) begin
                st  <= W_APP_RD;
                idx <= '0;
              end else begin
                rd_ptr <= bufa;
                rem    <= nwords;
                st     <= data_st;
              end
            end
          endcase
        end
        W_APP_RD: if (mem_ack) begin
          hold <= mem_rdata;
          st   <= W_APP_TX;
        end
        W_APP_TX: if (ctl_ready) begin
          if (idx == IDX_APPL) begin
            rd_ptr <= bufa;
            rem    <= nwords;
            st     <= data_st;
          end else begin
            idx <= idx + 3'd1;
            st  <= W_APP_RD;
          end
        end
        W_DAT_RD: if (mem_ack) begin
          hold <= mem_rdata;
          st   <= W_DAT_TX;
        end
        W_DAT_TX: if (tx_ready) begin
          rem    <= rem - CNT_W'(1);
          rd_ptr <= rd_ptr + AW'(4);
          st     <= (rem == CNT_W'(1)) ? W_WB : W_DAT_RD;
        end
        W_WB: if (mem_ack) st <= W_NEXT;
        W_NEXT: begin
          cur_ptr <= nxt;
          st      <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgdma_mm2s.sv
module sgdma_mm2s #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          ctrl_run,
  input  logic          ctrl_reset,
  input  logic          cur_wr,
  input  logic          tail_wr,
  input  logic [AW-1:0] ptr_wdata,
  output logic [AW-1:0] cur_ptr,
  output logic          st_halted,
  output logic          st_idle,
  output logic          st_rst_busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic [31:0]   tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_last,
  output logic [31:0]   ctl_data,
  output logic          ctl_valid,
  input  logic          ctl_ready,
  output logic          ctl_last,
  output logic          desc_done
);
  logic [AW-1:0] tail_ptr;
  logic          go, evt_halt, evt_idle;

  sgdma_csr #(.AW(AW)) u_csr (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_run(ctrl_run),
    .ctrl_reset(ctrl_reset), .tail_wr(tail_wr), .ptr_wdata(ptr_wdata),
    .evt_halt(evt_halt), .evt_idle(evt_idle), .tail_ptr(tail_ptr),
    .halted(st_halted), .idle(st_idle), .rst_busy(st_rst_busy), .go(go)
  );

  sgdma_walker #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .go(go), .flush(st_rst_busy), .cur_wr(cur_wr),
    .ptr_wdata(ptr_wdata), .tail_ptr(tail_ptr), .cur_ptr(cur_ptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
    .ctl_data(ctl_data), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
    .ctl_last(ctl_last), .evt_halt(evt_halt), .evt_idle(evt_idle),
    .desc_done(desc_done)
  );
endmodule

// File: rtl/sgdma_mm2s_chk.sv
module sgdma_mm2s_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_halted,
  input logic          st_idle,
  input logic          st_rst_busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic [31:0]   tx_data,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          tx_last,
  input logic [31:0]   ctl_data,
  input logic          ctl_valid,
  input logic          ctl_ready,
  input logic          ctl_last
);
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R7
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && !ctl_ready) |=> (ctl_valid && $stable(ctl_data) && $stable(ctl_last)));

  // R2
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_rst_busy |=> !st_rst_busy);

  // R6
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_halted) && !st_rst_busy) |-> (!mem_req && !tx_valid && !ctl_valid));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_idle) |-> (!mem_req && !tx_valid));

  // R8
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
endmodule

bind sgdma_mm2s sgdma_mm2s_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_halted(st_halted), .st_idle(st_idle),
  .st_rst_busy(st_rst_busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .tx_data(tx_data),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
  .ctl_data(ctl_data), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
  .ctl_last(ctl_last)
);

// File: tb/sim_sgdma_mm2s.sv
`timescale 1ns/1ps
module sim_sgdma_mm2s;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 0, ctrl_run = 0, ctrl_reset = 0, cur_wr = 0, tail_wr = 0;
  logic [31:0] ptr_wdata = '0;
  logic [31:0] cur_ptr, mem_addr, mem_wdata, tx_data, ctl_data;
  logic        st_halted, st_idle, st_rst_busy, mem_req, mem_we;
  logic        mem_ack = 0;
  logic [31:0] mem_rdata = '0;
  logic        tx_valid, tx_last, ctl_valid, ctl_last, desc_done;
  logic        tx_ready = 1, ctl_ready = 1;

  always #4 clk = ~clk;

  sgdma_mm2s u0 (.*);

  int tests = 0, fails = 0;
  logic [31:0] mem [0:255];
  logic [31:0] txq [0:31];
  logic        txl [0:31];
  logic [31:0] ctq [0:15];
  logic        ctl_l [0:15];
  int tx_n = 0, ct_n = 0, done_n = 0, req_n = 0, wr_n = 0;
  int cyc = 0, lat = 0, wcnt = 0;
  bit stall = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // stream sinks, memory model and event counters, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    tx_ready  = stall ? (cyc % 3 != 2) : 1'b1;
    ctl_ready = stall ? (cyc % 2 == 0) : 1'b1;
    if (tx_valid && tx_ready && tx_n < 32) begin
      txq[tx_n] = tx_data; txl[tx_n] = tx_last; tx_n++;
    end
    if (ctl_valid && ctl_ready && ct_n < 16) begin
      ctq[ct_n] = ctl_data; ctl_l[ct_n] = ctl_last; ct_n++;
    end
    if (desc_done) done_n++;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      req_n++;
      if (wcnt >= lat) begin
        if (mem_we) begin mem[mem_addr[9:2]] = mem_wdata; wr_n++; end
        else mem_rdata = mem[mem_addr[9:2]];
        mem_ack = 1'b1;
        wcnt = 0;
      end else wcnt++;
    end
  end

  task automatic clr_counts();
    tx_n = 0; ct_n = 0; done_n = 0; req_n = 0; wr_n = 0;
  endtask

  task automatic ctrl(input bit run, input bit rst);
    @(negedge clk); ctrl_wr = 1; ctrl_run = run; ctrl_reset = rst;
    @(negedge clk); ctrl_wr = 0; ctrl_run = 0; ctrl_reset = 0;
  endtask

  task automatic set_cur(input logic [31:0] p);
    @(negedge clk); cur_wr = 1; ptr_wdata = p;
    @(negedge clk); cur_wr = 0;
  endtask

  task automatic set_tail(input logic [31:0] p);
    @(negedge clk); tail_wr = 1; ptr_wdata = p;
    @(negedge clk); tail_wr = 0;
  endtask

  function automatic logic [31:0] ctl_word(input int len, input bit sof, input bit eof);
    return (32'(len) & 32'h7F_FFFF) | (32'(sof) << 27) | (32'(eof) << 26);
  endfunction

  task automatic wdesc(input int a, input int nx, input int buf_a, input int len,
                       input bit sof, input bit eof, input logic [31:0] stat);
    mem[a/4]   = 32'(nx);
    mem[a/4+1] = 32'(buf_a);
    mem[a/4+2] = ctl_word(len, sof, eof);
    mem[a/4+3] = stat;
    for (int i = 0; i < 5; i++) mem[a/4+4+i] = 32'hA000_0000 | 32'(a + 16 + 4*i);
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ((st_idle || st_halted) && !mem_req) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(st_halted == 1, "R1 halted", 32'(st_halted), 1);
    chk(st_idle == 0, "R1 idle", 32'(st_idle), 0);
    chk(cur_ptr == 0, "R1 cur_ptr", cur_ptr, 0);
    chk(!mem_req && !tx_valid && !ctl_valid, "R1 quiet", 32'({mem_req, tx_valid, ctl_valid}), 0);
  endtask

  task automatic t_reset_bit();
    @(negedge clk); ctrl_wr = 1; ctrl_reset = 1; ctrl_run = 0;
    @(negedge clk); ctrl_reset = 0; ctrl_run = 1;   // run write while reset busy
    chk(st_rst_busy == 1, "R2 busy set", 32'(st_rst_busy), 1);
    chk(st_halted == 1, "R2 halted", 32'(st_halted), 1);
    @(negedge clk); ctrl_wr = 0; ctrl_run = 0;
    chk(st_rst_busy == 0, "R2 busy self-clear", 32'(st_rst_busy), 0);
    chk(st_halted == 1, "R3 run ignored in reset", 32'(st_halted), 1);
  endtask

  task automatic t_no_run();
    wdesc(32'h0C0, 32'h100, 32'h200, 8, 1, 1, 32'h8000_0000);
    set_cur(32'h0C0);
    clr_counts();
    set_tail(32'h0C0);
    repeat (30) @(negedge clk);
    chk(req_n == 0, "R4 no fetch without run", 32'(req_n), 0);
    chk(st_idle == 0, "R4 tail clears idle", 32'(st_idle), 0);
  endtask

  task automatic t_complete();
    clr_counts();
    ctrl(1, 0);
    chk(!st_halted && !st_idle, "R3 run clears halted/idle", 32'({st_halted, st_idle}), 0);
    wait_quiet();
    chk(st_halted == 1, "R6 halted on done desc", 32'(st_halted), 1);
    chk(tx_n == 0 && ct_n == 0, "R6 nothing sent", 32'(tx_n + ct_n), 0);
    chk(wr_n == 0 && done_n == 0, "R6 no write-back", 32'(wr_n + done_n), 0);
    chk(mem[32'h0CC/4] == 32'h8000_0000, "R6 status unchanged", mem[32'h0CC/4], 32'h8000_0000);
  endtask

  task automatic t_single();
    wdesc(32'h100, 32'h3F0, 32'h200, 10, 1, 1, 32'h0);
    set_cur(32'h100);
    set_tail(32'h100);
    clr_counts();
    ctrl(1, 0);
    wait_quiet();
    chk(ct_n == 5, "R7 five app words", 32'(ct_n), 5);
    for (int i = 0; i < 5; i++) begin
      chk(ctq[i] == (32'hA000_0000 | 32'(32'h110 + 4*i)), "R7 app word", ctq[i], 32'hA000_0000 | 32'(32'h110 + 4*i));
      chk(ctl_l[i] == (i == 4), "R7 ctl_last", 32'(ctl_l[i]), 32'(i == 4));
    end
    chk(tx_n == 3, "R5 ceil(10/4) words", 32'(tx_n), 3);
    for (int i = 0; i < 3; i++) begin
      chk(txq[i] == (32'hB000_0000 | 32'(32'h200 + 4*i)), "R5 data word", txq[i], 32'hB000_0000 | 32'(32'h200 + 4*i));
      chk(txl[i] == (i == 2), "R8 tx_last", 32'(txl[i]), 32'(i == 2));
    end
    chk(mem[32'h10C/4] == 32'h8000_000A, "R9 status write-back", mem[32'h10C/4], 32'h8000_000A);
    chk(done_n == 1, "R10 one done pulse", 32'(done_n), 1);
    chk(cur_ptr == 32'h3F0, "R10 cur takes next", cur_ptr, 32'h3F0);
    chk(st_idle == 1, "R10 idle at tail", 32'(st_idle), 1);
  endtask

  task automatic t_chain();
    logic [31:0] ex [0:4];
    ex[0] = 32'hB000_0240; ex[1] = 32'hB000_0244; ex[2] = 32'hB000_0280;
    ex[3] = 32'hB000_0284; ex[4] = 32'hB000_02C0;
    wdesc(32'h140, 32'h180, 32'h240, 8, 1, 0, 32'h0);
    wdesc(32'h180, 32'h1C0, 32'h280, 5, 0, 0, 32'h0);
    wdesc(32'h1C0, 32'h100, 32'h2C0, 4, 0, 1, 32'h0);
    stall = 1; lat = 2;
    set_cur(32'h140);
    clr_counts();
    set_tail(32'h1C0);
    wait_quiet();
    stall = 0; lat = 0;
    chk(ct_n == 5, "R7 app words only on SOF", 32'(ct_n), 5);
    chk(tx_n == 5, "R8 words across descriptors", 32'(tx_n), 5);
    for (int i = 0; i < 5; i++) begin
      chk(txq[i] == ex[i], "R11 stalled data order", txq[i], ex[i]);
      chk(txl[i] == (i == 4), "R8 last only on EOF end", 32'(txl[i]), 32'(i == 4));
    end
    chk(mem[32'h14C/4] == 32'h8000_0008, "R9 status A", mem[32'h14C/4], 32'h8000_0008);
    chk(mem[32'h18C/4] == 32'h8000_0005, "R9 status B", mem[32'h18C/4], 32'h8000_0005);
    chk(mem[32'h1CC/4] == 32'h8000_0004, "R9 status C", mem[32'h1CC/4], 32'h8000_0004);
    chk(done_n == 3, "R10 done pulses", 32'(done_n), 3);
    chk(cur_ptr == 32'h100, "R10 cur after chain", cur_ptr, 32'h100);
  endtask

  task automatic t_tail_mid();
    wdesc(32'h300, 32'h340, 32'h380, 4, 1, 1, 32'h0);
    wdesc(32'h340, 32'h3C0, 32'h390, 4, 1, 1, 32'h0);
    set_cur(32'h300);
    clr_counts();
    set_tail(32'h300);
    wait_quiet();
    chk(tx_n == 1 && done_n == 1, "R10 stop at tail", 32'(tx_n), 1);
    chk(cur_ptr == 32'h340, "R10 cur at next", cur_ptr, 32'h340);
    chk(st_idle == 1, "R10 idle", 32'(st_idle), 1);
    ctrl(0, 0);
    clr_counts();
    set_tail(32'h340);
    repeat (30) @(negedge clk);
    chk(req_n == 0, "R4 run clear blocks fetch", 32'(req_n), 0);
    ctrl(1, 0);
    wait_quiet();
    chk(tx_n == 1 && txq[0] == 32'hB000_0390, "R4 resumes after run", txq[0], 32'hB000_0390);
    chk(cur_ptr == 32'h3C0, "R10 cur after second", cur_ptr, 32'h3C0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hB000_0000 | 32'(i * 4);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_bit();
    t_no_run();
    t_complete();
    t_single();
    t_chain();
    t_tail_mid();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule